// File: doc/BRIEF.md
# GPIO Interrupt Source Controller

This block turns one general-purpose pin into a source for an active-low interrupt line. A host sets it up through a small register interface with a write strobe and a read strobe. A two-bit setup field puts the pin in input mode, an enable bit gates the interrupt, and a two-bit trigger field selects the condition that raises it: low level, high level, falling edge or rising edge. The pin goes through a synchronizer first, and edges are found by comparing the synchronized level with its value one cycle earlier.

When the chosen condition occurs, a status bit is set and the interrupt output is pulled low. The host reads the status register to acknowledge. The read clears the status only if the condition is absent in that cycle. An edge event lasts one cycle, so a read clears an edge interrupt unless a new edge arrives in the same cycle. A level that is still present keeps the interrupt asserted across reads. Disarming the pin, by clearing the enable bit or by moving the setup field off input mode, drops the interrupt.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the status is 0, `irq_n_o` is 1, and the setup register (address 0x3) and control register (address 0x7) both read as 0.
- R2: The pin is armed only when setup bits [1:0] at address 0x3 equal 01. With any other setup value the status stays 0 and `irq_n_o` stays 1, whatever the pin does.
- R3: Control bit 0 at address 0x7 is the enable. When it is 0 the status stays 0 and `irq_n_o` stays 1.
- R4: Control bits [5:4] select the trigger: 00 low level, 01 high level, 10 falling edge, 11 rising edge. When the pin changes between clock edges, the status is set on the third rising clock edge after the change, and not sooner.
- R5: Bit 0 of address 0x9 returns the status during the read cycle. `irq_n_o` is low exactly when the status is 1.
- R6: In an edge mode, a read of address 0x9 clears the status at the end of the read cycle.
- R7: If an edge event falls in the same cycle as a status read, the status ends the cycle set.
- R8: In a level mode, a status read leaves the status set while the synchronized pin is still at the active level. A read after the level has gone clears it.
- R9: Writing the enable to 0, or writing a setup value other than 01, clears the status and releases `irq_n_o` one clock edge after the write takes effect.
- R10: Control and setup registers read back all bits as written. Reads of unmapped addresses and reads with the strobe low return 0. Writes to address 0x9 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | General-purpose pin level (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of 0x9 is the acknowledge |
| addr_i | input | ADDR_W (4) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| rdata_o | output | DATA_W (8) | Read data, valid in the cycle the read strobe is high |
| status_o | output | 1 | Interrupt status bit |
| irq_n_o | output | 1 | Active-low interrupt output |

## Verification
The bench sweeps every combination of setup value, enable and trigger mode. In each one it moves the pin from the mode's inactive level to its active level and back, with reads at fixed points. This separates the armed case from both kinds of disarmed case, and it separates level modes, which hold across a read, from edge modes, which clear on the read. A check one cycle before the expected set catches latency errors. A read placed in the same cycle as a rising-edge event tests the priority of a new trigger over the acknowledge. Disarming during an active high level, first with the enable and then with the setup field, shows that the interrupt drops even though the level is still present.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam logic [1:0] SETUP_INPUT = 2'b01;
  localparam int ADDR_SETUP = 3;
  localparam int ADDR_CTRL  = 7;
  localparam int ADDR_STAT  = 9;
  localparam int EN_BIT     = 0;
  localparam int TRIG_LSB   = 4;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = pin_i;
      end else begin : g_rest
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
(
  input  logic  lvl_i,
  input  logic  prev_i,
  input  trig_e mode_i,
  output logic  hit_o,
  output logic  is_level_o
);
  always_comb begin
    case (mode_i)
      TRIG_LOW:  hit_o = ~lvl_i;
      TRIG_HIGH: hit_o = lvl_i;
      TRIG_FALL: hit_o = prev_i & ~lvl_i;
      default:   hit_o = lvl_i & ~prev_i;
    endcase
  end

  assign is_level_o = (mode_i == TRIG_LOW) || (mode_i == TRIG_HIGH);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  output logic              en_o,
  output logic [1:0]        setup_o,
  output trig_e             mode_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, setup_q, setup_d;
  logic              ctrl_we, setup_we;

  assign ctrl_we  = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign setup_we = wr_en_i && (addr_i == ADDR_W'(ADDR_SETUP));

  always_comb begin
    ctrl_d  = ctrl_q;
    setup_d = setup_q;
    if (ctrl_we)  ctrl_d  = wdata_i;
    if (setup_we) setup_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      setup_q <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (setup_we) setup_q <= setup_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == ADDR_W'(ADDR_CTRL))       rdata_o = ctrl_q;
      else if (addr_i == ADDR_W'(ADDR_SETUP)) rdata_o = setup_q;
      else if (addr_i == ADDR_W'(ADDR_STAT))  rdata_o = DATA_W'(status_i);
    end
  end

  assign en_o    = ctrl_q[EN_BIT];
  assign setup_o = setup_q[1:0];
  assign mode_o  = trig_e'(ctrl_q[TRIG_LSB+1:TRIG_LSB]);
  assign ack_o   = rd_en_i && (addr_i == ADDR_W'(ADDR_STAT));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(ctrl_q) && $stable(setup_q)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              status_o,
  output logic              irq_n_o
);
  logic       rst_n_s;
  logic       lvl, prev, hit, is_level, ack, en;
  logic [1:0] setup;
  trig_e      mode;
  logic       armed, status_q, status_d;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  gpio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .pin_i(pin_i), .lvl_o(lvl), .prev_o(prev));

  gpio_trig_detect u_det (
    .lvl_i(lvl), .prev_i(prev), .mode_i(mode), .hit_o(hit), .is_level_o(is_level));

  gpio_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status_q),
    .en_o(en), .setup_o(setup), .mode_o(mode), .ack_o(ack), .rdata_o(rdata_o));

  assign armed = en && (setup == SETUP_INPUT);

  // New trigger wins over acknowledge; disarm wins over both.
  always_comb begin
    status_d = status_q;
    if (!armed)   status_d = 1'b0;
    else if (hit) status_d = 1'b1;
    else if (ack) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) status_q <= 1'b0;
    else          status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_n_o  = ~status_q;

  // R9
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !armed |=> !status_q);
  // R4
  set_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(status_q) |-> $past(hit));
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && is_level && hit) |=> status_q);
  // R6
  edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (armed && ack && !hit) |=> !status_q);
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          status, irq_n;
  int            n_chk = 0, n_bad = 0;
  logic          done = 1'b0;

  gpio_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .status_o(status), .irq_n_o(irq_n));

  always #2 clk = ~clk;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_en = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string what);
    chk(DW'(status), DW'(exp), {what, " status"});
    chk(DW'(irq_n), DW'(!exp), {what, " irq_n"});
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    rd(7, d); chk(d, 8'h00, "R1 ctrl reset");
    rd(3, d); chk(d, 8'h00, "R1 setup reset");
    // R10 readback, unmapped, strobe low, status write ignored
    wr(7, 8'hA6); rd(7, d); chk(d, 8'hA6, "R10 ctrl readback");
    wr(3, 8'h5C); rd(3, d); chk(d, 8'h5C, "R10 setup readback");
    rd(5, d); chk(d, 8'h00, "R10 unmapped read");
    addr = AW'(7); #1 chk(rdata, 8'h00, "R10 strobe low");
    wr(9, 8'hFF); rd(9, d); chk(d, 8'h00, "R10 status write ignored");
    wr(7, 8'h00); wr(3, 8'h00);

    // Sweep R2 R3 R4 R5 R6 R8
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 4; m++) begin
          logic armed, lvlm, act, hold;
          string tag;
          armed = (s == 1) && (e == 1);
          lvlm  = (m < 2);
          act   = m[0];
          hold  = armed && lvlm;
          tag   = $sformatf("s%0d e%0d m%0d", s, e, m);
          wr(7, 8'h00);
          pin = ~act;
          wr(3, DW'(s));
          step(4);
          wr(7, DW'((m << 4) | e));
          rd(9, d);
          step(1);
          chk_irq(1'b0, {"R2 R3 idle ", tag});
          pin = act;
          step(2);
          chk_irq(1'b0, {"R4 latency ", tag});
          step(1);
          chk_irq(armed, {"R2 R3 R4 set ", tag});
          rd(9, d);
          chk(d, DW'(armed), {"R5 readback ", tag});
          chk_irq(hold, {"R6 R8 after ack ", tag});
          pin = ~act;
          step(3);
          chk_irq(hold, {"R8 latched ", tag});
          rd(9, d);
          chk_irq(1'b0, {"R8 cleared ", tag});
        end

    // R7 edge in same cycle as read
    wr(7, 8'h00); pin = 1'b0; wr(3, 8'h01); step(4);
    wr(7, 8'h31); rd(9, d); step(1);
    chk_irq(1'b0, "R7 idle");
    pin = 1'b1;
    step(2);
    rd(9, d);
    chk(d, 8'h00, "R7 readback before set");
    chk_irq(1'b1, "R7 edge beats ack");
    rd(9, d);
    chk_irq(1'b0, "R7 later ack clears");

    // R9 disarm while level held
    wr(7, 8'h11); step(4);
    chk_irq(1'b1, "R9 armed high level");
    wr(7, 8'h10); step(1);
    chk_irq(1'b0, "R9 enable cleared");
    step(3);
    chk_irq(1'b0, "R9 stays clear");
    wr(7, 8'h11); step(2);
    chk_irq(1'b1, "R9 re-armed");
    wr(3, 8'h00); step(1);
    chk_irq(1'b0, "R9 setup changed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule